// File: doc/BRIEF.md
# Phase-Split Two-Read One-Write Register File

This block gives a pipelined processor two source-operand reads and one result write in every pipeline cycle. The storage array behind it offers only one access slot per access-clock edge. In each slot it can either deliver two independent reads or accept a single write. The block therefore runs on an access clock `clk` that is twice the pipeline rate, and it divides every pipeline cycle into two slots. The first slot serves both reads. The second slot commits the write.

Pipeline cycles are counted from reset release. The first rising edge of `clk` with `rst` low is edge 0. Every even-numbered edge is a request edge: it captures all five request inputs (both read addresses, the write enable, the write address and the write data) and opens a new cycle. The odd edge that follows is the read slot, and it loads both read results into the output registers. The next even edge is the write slot. It stores the captured write in the array and, on the same edge, captures the next cycle's request. Reads therefore always come before the write of the same cycle, and a written value can be seen from the following cycle onward.

Top module: `tmrf_2r1w`

## Requirements
- R1: While `rst` is high at a rising edge, both read data outputs become zero. The first rising edge with `rst` low is a request edge (edge 0).
- R2: Request inputs are sampled only at even-numbered edges counted from reset release. Any value they hold at an odd edge, including `wr_en` = 1, has no effect on read results or on register contents.
- R3: Read data for a request captured at edge 2k appears after edge 2k+1 and holds unchanged through edge 2k+2.
- R4: The two read ports are independent. Each returns the contents of the register named by its own address in the same cycle.
- R5: When both read addresses name the same register, both outputs return that register's contents.
- R6: A request with `wr_en` = 1 stores `wr_data` in register `wr_addr`, and reads in every later cycle return the new value.
- R7: A read of the register that the same cycle's request writes returns the value held before that write.
- R8: A request with `wr_en` = 0 changes no register.
- R9: Every register from 0 to `REGS`-1, register 0 included, can be written and read back with any value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Access clock, two edges per pipeline cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | AW = clog2(REGS) | Register read by port A |
| rd_addr_b | input | AW | Register read by port B |
| rd_data_a | output | WIDTH | Registered result of port A |
| rd_data_b | output | WIDTH | Registered result of port B |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | AW | Register to be written |
| wr_data | input | WIDTH | Value to be written |

## Verification
The case that matters is a read and a write aimed at the same register in the same pipeline cycle. The write slot must commit after the read slot has already latched its result. The bench provokes this by issuing one request whose write address matches a read address. It expects the old value in that cycle and the new value in the next one. It also changes every request input halfway through a cycle, including raising `wr_en`, and then confirms that the addressed results and the register that would have been hit are left untouched.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;

  // Access slot within one pipeline cycle.
  // SLOT_REQ  : request capture edge, also the write slot of the previous request
  // SLOT_READ : dual-read slot of the captured request
  typedef enum logic {
    SLOT_REQ  = 1'b0,
    SLOT_READ = 1'b1
  } slot_e;

  function automatic slot_e slot_after(input slot_e cur);
    return (cur == SLOT_REQ) ? SLOT_READ : SLOT_REQ;
  endfunction

endpackage

// File: rtl/tmrf_slot_seq.sv
module tmrf_slot_seq
  import tmrf_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] in_ra_a,
  input  logic [AW-1:0] in_ra_b,
  input  logic          in_we,
  input  logic [AW-1:0] in_wa,
  input  logic [DW-1:0] in_wd,
  output slot_e         slot,
  output logic [AW-1:0] q_ra_a,
  output logic [AW-1:0] q_ra_b,
  output logic          q_we,
  output logic [AW-1:0] q_wa,
  output logic [DW-1:0] q_wd
);

  logic take_req;
  assign take_req = (slot == SLOT_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= SLOT_REQ;
      q_ra_a <= '0;
      q_ra_b <= '0;
      q_we   <= 1'b0;
      q_wa   <= '0;
      q_wd   <= '0;
    end else begin
      slot <= slot_after(slot);
      if (take_req) begin
        q_ra_a <= in_ra_a;
        q_ra_b <= in_ra_b;
        q_we   <= in_we;
        q_wa   <= in_wa;
        q_wd   <= in_wd;
      end
    end
  end

endmodule

// File: rtl/tmrf_store.sv
module tmrf_store
  import tmrf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  slot_e         slot,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic          wen,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq_a,
  output logic [DW-1:0] rq_b
);

  localparam int NRD = 2;

  logic [DW-1:0] mem [DEPTH];
  logic [NRD-1:0][AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] rq;
  logic rd_stb;
  logic wr_stb;

  // one access per slot: a read pair or a single write, never both
  assign rd_stb = (slot == SLOT_READ);
  assign wr_stb = (slot == SLOT_REQ) && wen;

  assign raddr[0] = ra_a;
  assign raddr[1] = ra_b;

  always_ff @(posedge clk) begin
    if (wr_stb) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq <= '0;
    end else if (rd_stb) begin
      for (int p = 0; p < NRD; p++) rq[p] <= mem[raddr[p]];
    end
  end

  assign rq_a = rq[0];
  assign rq_b = rq[1];

endmodule

// File: rtl/tmrf_2r1w.sv
module tmrf_2r1w
  import tmrf_pkg::*;
#(
  parameter  int REGS  = 32,
  parameter  int WIDTH = 32,
  localparam int AW    = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_a,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);

  slot_e            slot;
  logic [AW-1:0]    q_ra_a;
  logic [AW-1:0]    q_ra_b;
  logic             q_we;
  logic [AW-1:0]    q_wa;
  logic [WIDTH-1:0] q_wd;

  tmrf_slot_seq #(.AW(AW), .DW(WIDTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .in_ra_a (rd_addr_a),
    .in_ra_b (rd_addr_b),
    .in_we   (wr_en),
    .in_wa   (wr_addr),
    .in_wd   (wr_data),
    .slot    (slot),
    .q_ra_a  (q_ra_a),
    .q_ra_b  (q_ra_b),
    .q_we    (q_we),
    .q_wa    (q_wa),
    .q_wd    (q_wd)
  );

  tmrf_store #(.DEPTH(REGS), .AW(AW), .DW(WIDTH)) u_store (
    .clk  (clk),
    .rst  (rst),
    .slot (slot),
    .ra_a (q_ra_a),
    .ra_b (q_ra_b),
    .wen  (q_we),
    .wa   (q_wa),
    .wd   (q_wd),
    .rq_a (rd_data_a),
    .rq_b (rd_data_b)
  );

endmodule

// File: rtl/tmrf_2r1w_chk.sv
module tmrf_2r1w_chk
  import tmrf_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input slot_e         slot,
  input logic [AW-1:0] q_ra_a,
  input logic [AW-1:0] q_ra_b,
  input logic [DW-1:0] rd_data_a,
  input logic [DW-1:0] rd_data_b
);

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_data_a == '0 && rd_data_b == '0));

  // R2
  req_align_chk: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (slot == SLOT_REQ));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_REQ) |=> ($stable(rd_data_a) && $stable(rd_data_b)));

  // R5
  same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_READ && q_ra_a == q_ra_b) |=> (rd_data_a == rd_data_b));

endmodule

bind tmrf_2r1w tmrf_2r1w_chk #(.AW(AW), .DW(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slot      (slot),
  .q_ra_a    (q_ra_a),
  .q_ra_b    (q_ra_b),
  .rd_data_a (rd_data_a),
  .rd_data_b (rd_data_b)
);

// File: tb/tmrf_2r1w_test.sv
module tmrf_2r1w_test;

  localparam int REGS = 32;
  localparam int W    = 32;
  localparam int AW   = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr_a = '0;
  logic [AW-1:0] rd_addr_b = '0;
  logic [W-1:0]  rd_data_a;
  logic [W-1:0]  rd_data_b;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model [REGS];

  always #2 clk = ~clk;

  tmrf_2r1w #(.REGS(REGS), .WIDTH(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One pipeline cycle; entered and left at the falling edge before a request edge.
  task automatic run_cycle(input logic [AW-1:0] a, input logic [AW-1:0] b,
                           input logic we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                           input logic disturb,
                           output logic [W-1:0] mid_a, output logic [W-1:0] mid_b,
                           output logic [W-1:0] res_a, output logic [W-1:0] res_b);
    rd_addr_a = a; rd_addr_b = b; wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk); @(negedge clk);
    mid_a = rd_data_a; mid_b = rd_data_b;
    if (disturb) begin
      rd_addr_a = ~a; rd_addr_b = ~b; wr_en = 1'b1; wr_addr = ~wa; wr_data = ~wd;
    end
    @(posedge clk); @(negedge clk);
    res_a = rd_data_a; res_b = rd_data_b;
    if (we) model[wa] = wd;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset port A", rd_data_a, '0);
    check("R1 reset port B", rd_data_b, '0);
    rst = 1'b0;
  endtask

  task automatic t_fill;
    logic [W-1:0] ma, mb, ra, rb;
    for (int i = 0; i < REGS; i++)
      run_cycle('0, '0, 1'b1, AW'(i), 32'h9E3779B9 * W'(i + 1), 1'b0, ma, mb, ra, rb);
    for (int i = 0; i < REGS / 2; i++) begin
      run_cycle(AW'(i), AW'(REGS - 1 - i), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
      check("R4 R9 port A readback", ra, model[i]);
      check("R4 R9 port B readback", rb, model[REGS - 1 - i]);
    end
  endtask

  task automatic t_same_addr;
    logic [W-1:0] ma, mb, ra, rb;
    run_cycle(AW'(5), AW'(5), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R5 same address A", ra, model[5]);
    check("R5 same address B", rb, model[5]);
    run_cycle('0, '0, 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R5 R9 register 0 on both ports", ra, model[0]);
    check("R5 R9 register 0 on both ports", rb, model[0]);
  endtask

  task automatic t_read_during_write;
    logic [W-1:0] ma, mb, ra, rb, old7;
    old7 = model[7];
    run_cycle(AW'(7), AW'(9), 1'b1, AW'(7), 32'hCAFE0007, 1'b0, ma, mb, ra, rb);
    check("R7 same-cycle read returns old value", ra, old7);
    check("R4 other port unaffected", rb, model[9]);
    run_cycle(AW'(9), AW'(7), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R6 new value visible next cycle", rb, 32'hCAFE0007);
    check("R6 neighbour register unchanged", ra, model[9]);
  endtask

  task automatic t_we_low;
    logic [W-1:0] ma, mb, ra, rb, keep;
    keep = model[3];
    run_cycle(AW'(1), AW'(2), 1'b0, AW'(3), 32'hDEADBEEF, 1'b0, ma, mb, ra, rb);
    run_cycle(AW'(3), AW'(3), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R8 disabled write leaves register", ra, keep);
  endtask

  task automatic t_midcycle_ignored;
    logic [W-1:0] ma, mb, ra, rb;
    // Odd-edge inputs: addresses 30/29, wr_en=1 to register 27 with 0x00FF00FF
    run_cycle(AW'(1), AW'(2), 1'b0, AW'(4), 32'hFF00FF00, 1'b1, ma, mb, ra, rb);
    check("R2 port A address taken at request edge", ra, model[1]);
    check("R2 port B address taken at request edge", rb, model[2]);
    run_cycle(AW'(27), AW'(4), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R2 odd-edge write ignored", ra, model[27]);
    check("R2 odd-edge write ignored at request address", rb, model[4]);
  endtask

  task automatic t_hold;
    logic [W-1:0] ma, mb, ra, rb, pa, pb;
    run_cycle(AW'(10), AW'(11), 1'b0, '0, '0, 1'b0, ma, mb, pa, pb);
    check("R3 result port A", pa, model[10]);
    check("R3 result port B", pb, model[11]);
    run_cycle(AW'(12), AW'(13), 1'b0, '0, '0, 1'b0, ma, mb, ra, rb);
    check("R3 port A held over request edge", ma, pa);
    check("R3 port B held over request edge", mb, pb);
    check("R3 next result port A", ra, model[12]);
    check("R3 next result port B", rb, model[13]);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_same_addr();
    t_read_during_write();
    t_we_low();
    t_midcycle_ignored();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule